// File: doc/BRIEF.md
# Compact I/O Sequencing Processor

This block is a small controller that runs a fixed program held in an instruction ROM and moves bytes between a handful of 8-bit registers and an 8-bit I/O address space. A typical use is glue firmware that polls a status port, masks a ready bit, branches on the result and copies a data byte from one peripheral to another. Each instruction is 16 bits wide. The top nibble selects the operation, the next nibble selects a register, and the low byte carries an immediate value or an I/O address. Call and jump use the low 12 bits as an absolute target.

Every instruction takes exactly four clocks. A two-bit Gray-coded phase counter steps through fetch, decode, execute and retire, so only one phase bit toggles per clock. The ROM is read asynchronously: the core presents the program counter on `rom_addr` and latches `rom_data` at the end of the fetch clock. The I/O side uses plain strobes rather than valid/ready. A device must accept a write, or have read data ready, within the single clock in which the strobe is high. Nothing is buffered and the core never waits, so no back-pressure reaches the program.

Subroutine return addresses sit in a small circular hardware stack. Nesting deeper than the stack overwrites the oldest entry without raising an error.

Top module: `iop_core`

## Requirements
- R1: After reset `rom_addr` is 0, `io_rd` and `io_wr` are low, every register reads 0 and the zero flag is clear, so a branch-if-zero (opcode 0xC) placed first is not taken.
- R2: The program counter on `rom_addr` changes only at the end of the fourth clock of an instruction. After reset release it still reads 0 after three rising edges and reads the next address after the fourth.
- R3: Opcode 0x2 loads bits 7:0 into the register named by bits 11:8. Opcode 0x7 drives that register on `io_wdata` and bits 7:0 on `io_addr` while pulsing `io_wr`.
- R4: Opcode 0x6 pulses `io_rd` with bits 7:0 on `io_addr` and stores `io_rdata`, sampled in that same clock, into the selected register.
- R5: Opcode 0x8 ANDs the selected register with bits 7:0 and opcode 0x9 ORs it with bits 7:0. Both write the result back to the register.
- R6: Opcode 0xC adds bits 11:0 to its own address, modulo 4096, when the zero flag is set, and otherwise continues at the next address. Only opcode 0x8 updates the flag, which is set when the AND result is zero. OR, load, I/O and control-flow instructions leave it unchanged.
- R7: Opcode 0xE continues at the absolute address held in bits 11:0.
- R8: Opcode 0xA pushes its own address plus one and continues at bits 11:0. Opcode 0xB pops and continues at the popped address. Nested calls return in last-in-first-out order.
- R9: The return stack holds 4 entries and wraps. After a fifth nested call, the fifth return yields the fifth call's return address again.
- R10: `io_rd` and `io_wr` are never high together. Each is high for exactly one clock, the third clock of an instruction counted from its fetch.
- R11: There are 4 registers, selected by bits 9:8 of the instruction. Bits 11:10 are ignored, so register field 6 names register 2. A write to one register leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | 12 | Program counter presented to the instruction ROM |
| rom_data | input | 16 | Instruction word read asynchronously from `rom_addr` |
| io_addr | output | 8 | I/O port address, valid while a strobe is high |
| io_wdata | output | 8 | Write data, valid while `io_wr` is high |
| io_rdata | input | 8 | Read data, sampled in the clock where `io_rd` is high |
| io_rd | output | 1 | One-clock I/O read strobe |
| io_wr | output | 1 | One-clock I/O write strobe |

## Verification
A phase counter that drifts out of step shows up at once as a strobe outside the third clock, or as a program counter step at the wrong clock, and both are visible within one instruction. A wrong zero flag or a corrupted register does not show until the next write strobe. That write then goes to the wrong port or carries the wrong byte, which is why every program in the sweep ends each decision with a write. A damaged return stack shows up one return later, as writes out of order, and the wrap test compares the first six writes of a deliberately over-deep call chain.

// File: rtl/iop_pkg.sv
package iop_pkg;

  localparam int INSN_W = 16;

  typedef enum logic [3:0] {
    OP_LDI  = 4'h2,
    OP_IN   = 4'h6,
    OP_OUT  = 4'h7,
    OP_ANDI = 4'h8,
    OP_ORI  = 4'h9,
    OP_CALL = 4'hA,
    OP_RET  = 4'hB,
    OP_BZ   = 4'hC,
    OP_GOTO = 4'hE
  } opcode_e;

  // Gray sequence: one bit changes per step
  typedef enum logic [1:0] {
    PH_FETCH  = 2'b00,
    PH_DECODE = 2'b01,
    PH_EXEC   = 2'b11,
    PH_RETIRE = 2'b10
  } phase_e;

endpackage

// File: rtl/iop_phase.sv
module iop_phase
  import iop_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);

  phase_e phase_nx;

  always_comb begin
    unique case (phase)
      PH_FETCH:  phase_nx = PH_DECODE;
      PH_DECODE: phase_nx = PH_EXEC;
      PH_EXEC:   phase_nx = PH_RETIRE;
      default:   phase_nx = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= phase_nx;
  end

endmodule

// File: rtl/iop_regfile.sv
module iop_regfile #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_sel,
  input  logic [DW-1:0] wr_val,
  input  logic [RW-1:0] rd_sel,
  output logic [DW-1:0] rd_val
);

  logic [DW-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                              bank[g] <= '0;
      else if (wr_en && wr_sel == RW'(g))      bank[g] <= wr_val;
    end
  end

  assign rd_val = bank[rd_sel];

endmodule

// File: rtl/iop_retstack.sv
module iop_retstack #(
  parameter int DEPTH = 4,
  parameter int AW    = 12,
  localparam int SW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_val,
  output logic [AW-1:0] top_val
);

  // DEPTH is a power of two so the pointer wraps naturally
  logic [AW-1:0] slot [DEPTH];
  logic [SW-1:0] wptr;
  logic [SW-1:0] tptr;

  assign tptr    = wptr - SW'(1);
  assign top_val = slot[tptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
    end else if (push) begin
      slot[wptr] <= push_val;
      wptr       <= wptr + SW'(1);
    end else if (pop) begin
      wptr <= tptr;
    end
  end

endmodule

// File: rtl/iop_core.sv
module iop_core
  import iop_pkg::*;
#(
  parameter int PC_W        = 12,
  parameter int DW          = 8,
  parameter int NREG        = 4,
  parameter int STACK_DEPTH = 4,
  localparam int RW         = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   rom_addr,
  input  logic [INSN_W-1:0] rom_data,
  output logic [7:0]        io_addr,
  output logic [DW-1:0]     io_wdata,
  input  logic [DW-1:0]     io_rdata,
  output logic              io_rd,
  output logic              io_wr
);

  phase_e            phase;
  logic [INSN_W-1:0] ir;
  logic [PC_W-1:0]   pc;
  logic [PC_W-1:0]   pc_nx;
  logic [PC_W-1:0]   pc_inc;
  logic [PC_W-1:0]   ret_top;
  logic              zflag;
  logic [3:0]        op;
  logic [RW-1:0]     rsel;
  logic [DW-1:0]     imm;
  logic [DW-1:0]     rval;
  logic [DW-1:0]     wval;
  logic [DW-1:0]     and_res;
  logic              rwe;
  logic              in_exec;
  logic              in_retire;

  iop_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  assign op        = ir[15:12];
  assign rsel      = ir[8 +: RW];
  assign imm       = ir[DW-1:0];
  assign in_exec   = (phase == PH_EXEC);
  assign in_retire = (phase == PH_RETIRE);
  assign and_res   = rval & imm;
  assign pc_inc    = pc + PC_W'(1);

  always_comb begin
    rwe  = 1'b0;
    wval = rval;
    unique case (op)
      OP_LDI:  begin rwe = 1'b1; wval = imm;        end
      OP_IN:   begin rwe = 1'b1; wval = io_rdata;   end
      OP_ANDI: begin rwe = 1'b1; wval = and_res;    end
      OP_ORI:  begin rwe = 1'b1; wval = rval | imm; end
      default: ;
    endcase
  end

  iop_regfile #(.NREG(NREG), .DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (in_exec && rwe),
    .wr_sel (rsel),
    .wr_val (wval),
    .rd_sel (rsel),
    .rd_val (rval)
  );

  iop_retstack #(.DEPTH(STACK_DEPTH), .AW(PC_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (in_retire && op == OP_CALL),
    .pop      (in_retire && op == OP_RET),
    .push_val (pc_inc),
    .top_val  (ret_top)
  );

  always_comb begin
    unique case (op)
      OP_GOTO, OP_CALL: pc_nx = ir[PC_W-1:0];
      OP_RET:           pc_nx = ret_top;
      OP_BZ:            pc_nx = zflag ? pc + ir[PC_W-1:0] : pc_inc;
      default:          pc_nx = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir    <= '0;
      pc    <= '0;
      zflag <= 1'b0;
    end else begin
      if (phase == PH_FETCH)        ir    <= rom_data;
      if (in_exec && op == OP_ANDI) zflag <= (and_res == '0);
      if (in_retire)                pc    <= pc_nx;
    end
  end

  assign rom_addr = pc;
  assign io_addr  = ir[7:0];
  assign io_wdata = rval;
  assign io_rd    = in_exec && (op == OP_IN);
  assign io_wr    = in_exec && (op == OP_OUT);

endmodule

// File: rtl/iop_core_chk.sv
module iop_core_chk #(
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] rom_addr,
  input logic            io_rd,
  input logic            io_wr
);

  // independent clock counter modulo the instruction length
  logic [1:0] beat;
  always_ff @(posedge clk) begin
    if (!rst_n) beat <= 2'd0;
    else        beat <= beat + 2'd1;
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rom_addr) |-> beat == 2'd0);

  p_excl_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_rd && io_wr));

  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |=> !io_rd);

  p_wr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> !io_wr);

  p_rd_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd |-> beat == 2'd2);

  p_wr_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |-> beat == 2'd2);

endmodule

bind iop_core iop_core_chk #(.PC_W(PC_W)) u_core_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rom_addr (rom_addr),
  .io_rd    (io_rd),
  .io_wr    (io_wr)
);

// File: tb/test_iop_core.sv
module test_iop_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] rom_addr;
  logic [15:0] rom_data;
  logic [7:0]  io_addr, io_wdata, io_rdata;
  logic        io_rd, io_wr;

  logic [15:0] rom [64];
  int          errors = 0, checks = 0, cyc = 0;
  int          nw = 0, nr = 0, overlap = 0;
  logic [7:0]  wa [16];
  logic [7:0]  wd [16];
  int          rdc [8];
  logic [11:0] addr_at [8];

  always #2.5 clk = ~clk;

  assign rom_data = rom[rom_addr[5:0]];
  assign io_rdata = io_addr ^ 8'h5A;

  iop_core i_iop_core (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rd(io_rd), .io_wr(io_wr)
  );

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc < 8) addr_at[cyc] = rom_addr;
      if (io_wr && nw < 16) begin wa[nw] = io_addr; wd[nw] = io_wdata; end
      if (io_wr) nw++;
      if (io_rd && nr < 8) rdc[nr] = cyc;
      if (io_rd) nr++;
      if (io_rd && io_wr) overlap++;
    end
  end

  function automatic logic [15:0] ins(input logic [3:0] op, input logic [3:0] r, input logic [7:0] v);
    return {op, r, v};
  endfunction

  function automatic logic [15:0] far(input logic [3:0] op, input logic [11:0] t);
    return {op, t};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = 16'h0000;
  endtask

  task automatic start_and_run(input int n);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    nw = 0; nr = 0; overlap = 0;
    rst_n = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_w(input int k, input logic [7:0] a, input logic [7:0] d, input string tag);
    chk(nw > k && wa[k] == a, {tag, " write addr"}, (nw > k) ? int'(wa[k]) : -1, a);
    chk(nw > k && wd[k] == d, {tag, " write data"}, (nw > k) ? int'(wd[k]) : -1, d);
  endtask

  initial begin
    logic [7:0] masks [8];
    logic [7:0] a;
    masks = '{8'h00, 8'h01, 8'h80, 8'h0F, 8'hF0, 8'hFF, 8'h55, 8'hAA};

    // R1 reset state and R2 cadence
    clear_rom();
    rom[0] = far(4'hC, 12'h003);
    rom[1] = ins(4'h7, 4'h3, 8'h01);
    rom[2] = far(4'hE, 12'h002);
    rom[3] = ins(4'h7, 4'h3, 8'h02);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(rom_addr == 0 && !io_rd && !io_wr, "R1 reset outputs", rom_addr, 0);
    start_and_run(20);
    chk(addr_at[3] == 12'd0, "R2 pc held through clock 3", addr_at[3], 0);
    chk(addr_at[4] == 12'd1, "R2 pc steps after clock 4", addr_at[4], 1);
    chk(nw == 1, "R1 flag clear so one write", nw, 1);
    chk_w(0, 8'h01, 8'h00, "R1 register zero");

    // R3 R5 R6 R7 sweep over values and masks
    for (int vi = 0; vi < 16; vi++) begin
      for (int mi = 0; mi < 8; mi++) begin
        logic [7:0] v, m;
        v = 8'(vi * 17 + 3);
        m = masks[mi];
        a = v & m;
        clear_rom();
        rom[0]  = ins(4'h2, 4'h1, v);
        rom[1]  = ins(4'h8, 4'h1, m);
        rom[2]  = far(4'hC, 12'h003);
        rom[3]  = ins(4'h7, 4'h1, 8'h10);
        rom[4]  = far(4'hE, 12'h006);
        rom[5]  = ins(4'h7, 4'h1, 8'h20);
        rom[6]  = ins(4'h9, 4'h1, ~m);
        rom[7]  = ins(4'h7, 4'h1, 8'h30);
        rom[8]  = far(4'hC, 12'h003);
        rom[9]  = ins(4'h7, 4'h1, 8'h31);
        rom[10] = far(4'hE, 12'h00A);
        rom[11] = ins(4'h7, 4'h1, 8'h32);
        rom[12] = far(4'hE, 12'h00C);
        start_and_run(70);
        chk(nw == 3, "R7 jump skips, write count", nw, 3);
        chk_w(0, (a == 0) ? 8'h20 : 8'h10, a, "R6 branch after AND (R3 R5)");
        chk_w(1, 8'h30, a | ~m, "R5 OR result");
        chk_w(2, (a == 0) ? 8'h32 : 8'h31, a | ~m, "R6 flag kept across OR");
      end
    end

    // R4 R10 R11 read path and register independence
    for (int ai = 0; ai < 32; ai++) begin
      logic [7:0] p;
      p = 8'(ai * 8 + 1);
      clear_rom();
      rom[0] = ins(4'h2, 4'h0, 8'hC3);
      rom[1] = ins(4'h6, 4'h2, p);
      rom[2] = ins(4'h6, 4'h3, p + 8'd1);
      rom[3] = ins(4'h7, 4'h2, 8'h40);
      rom[4] = ins(4'h7, 4'h3, 8'h41);
      rom[5] = ins(4'h7, 4'h0, 8'h42);
      rom[6] = ins(4'h7, 4'h6, 8'h43);
      rom[7] = far(4'hE, 12'h007);
      start_and_run(40);
      chk(nr == 2 && rdc[0] == 6 && rdc[1] == 10, "R10 read strobe clocks", rdc[0], 6);
      chk(overlap == 0, "R10 strobes exclusive", overlap, 0);
      chk_w(0, 8'h40, p ^ 8'h5A, "R4 read capture");
      chk_w(1, 8'h41, (p + 8'd1) ^ 8'h5A, "R4 second read");
      chk_w(2, 8'h42, 8'hC3, "R11 r0 untouched");
      chk_w(3, 8'h43, p ^ 8'h5A, "R11 field 6 aliases r2");
    end

    // R8 nested call and return
    clear_rom();
    rom[0]  = far(4'hA, 12'd10);
    rom[1]  = ins(4'h7, 4'h0, 8'h50);
    rom[2]  = far(4'hE, 12'd2);
    rom[10] = ins(4'h2, 4'h0, 8'h11);
    rom[11] = far(4'hA, 12'd20);
    rom[12] = ins(4'h7, 4'h0, 8'h51);
    rom[13] = far(4'hB, 12'd0);
    rom[20] = ins(4'h2, 4'h0, 8'h22);
    rom[21] = far(4'hB, 12'd0);
    start_and_run(50);
    chk(nw == 2, "R8 write count", nw, 2);
    chk_w(0, 8'h51, 8'h22, "R8 inner return");
    chk_w(1, 8'h50, 8'h22, "R8 outer return");

    // R9 five-deep chain over a four-entry stack
    clear_rom();
    rom[0] = far(4'hA, 12'd8);
    rom[1] = ins(4'h7, 4'h0, 8'h7F);
    rom[2] = far(4'hE, 12'd2);
    for (int k = 1; k <= 5; k++) begin
      rom[8*k]   = ins(4'h2, 4'h0, 8'(k));
      rom[8*k+1] = (k < 5) ? far(4'hA, 12'(8*(k+1))) : far(4'hB, 12'd0);
      rom[8*k+2] = ins(4'h7, 4'h0, 8'(8'h70 + k));
      rom[8*k+3] = far(4'hB, 12'd0);
    end
    start_and_run(120);
    begin
      logic [7:0] seq [6];
      seq = '{8'h74, 8'h73, 8'h72, 8'h71, 8'h74, 8'h73};
      for (int k = 0; k < 6; k++) chk_w(k, seq[k], 8'h05, "R9 stack wrap order");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule